// File: doc/BRIEF.md
# Direct Branch Early Redirect at Decode

This block sits beside the decode stage of a multithreaded front end. A direct control transfer (PC-relative or absolute) has a target that can be computed without execution. When the target buffer missed for such an instruction and fetch went down the wrong path, the block recovers at decode. It squashes fetch for the thread, steers the thread's PC to the decoded target and unwinds one level of that thread's speculation depth. Indirect jumps need execution to learn their target, so they are left alone.

Each thread has a speculation-depth counter. The front end raises it with an entry strobe each time it starts a new speculative path, and every accepted fix-up lowers it by one. When a fix-up brings a thread's depth back to zero, the block sends a speculative-state reset for that thread. It also holds the thread's branch-recovery fetch-stall bit for exactly one cycle, so that fetch does not act on the redirect in the cycle it is issued. A fix-up that finds the depth already at zero is refused and reported on an error pulse. All outputs are registered. One decode slot is examined per cycle, so a thread receives at most one fix-up per cycle.

Top module: `branch_miss_redirect`

## Requirements
- R1: A fix-up is accepted when dec_valid, dec_direct, dec_miss and dec_pending are all 1 and the thread's effective depth is nonzero. squash_o is then 1 in the cycle after the input was sampled, and 0 in every other cycle.
- R2: If any one of dec_valid, dec_direct (0 means indirect), dec_miss or dec_pending is 0, there is no squash, no stall, no error and no change to any depth.
- R3: With squash_o, redirect_pc_o equals the sampled dec_target and squash_tid_o equals the sampled dec_tid. The squash pulse also tells the front end to clear the recovery-pending flag.
- R4: spec_enter raises the depth of thread spec_enter_tid by one, saturating at 2^DEPTH_W-1. Each accepted fix-up lowers the depth of its thread by one.
- R5: spec_reset_o is 1 together with squash_o exactly when the accepted fix-up brought the thread's depth to zero. It applies to thread squash_tid_o.
- R6: fetch_stall_o bit t is 1 for exactly the one cycle in which a squash for thread t is shown, and 0 otherwise.
- R7: A qualifying instruction whose thread's effective depth is zero produces depth_err_o = 1 in the next cycle. There is no squash and the depth stays at zero.
- R8: A spec_enter and a fix-up for the same thread in the same cycle are ordered with the entry first. The fix-up sees the raised depth, and the net depth is unchanged unless the counter was saturated.
- R9: After reset all outputs are 0 and every thread's depth is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_tid | input | TID_W | Thread of the decoded instruction |
| dec_direct | input | 1 | Instruction is a direct control transfer |
| dec_miss | input | 1 | Target-buffer lookup missed |
| dec_pending | input | 1 | Recovery still pending for this instruction |
| dec_target | input | PC_W | Computed branch target |
| spec_enter | input | 1 | Thread enters one more speculative level |
| spec_enter_tid | input | TID_W | Thread for spec_enter |
| squash_o | output | 1 | Fetch squash / pending clear pulse |
| squash_tid_o | output | TID_W | Thread squashed |
| redirect_pc_o | output | PC_W | New PC for squash_tid_o |
| spec_reset_o | output | 1 | Speculative state reset for squash_tid_o |
| fetch_stall_o | output | NUM_THREADS | One-cycle branch-recovery stall per thread |
| depth_err_o | output | 1 | Fix-up refused, depth was zero |

## Verification
The interesting collision is a depth increment and a fix-up landing on the same thread in the same cycle. The bench provokes this both by directed steps (starting from depth zero, where only the entry-first ordering makes the fix-up legal and raise a speculative reset) and by random traffic on a small thread count, where such coincidences are frequent. A behavioural model in the bench applies the entry before the fix-up, and every output is compared with it on every cycle. That comparison includes the split between a squash with reset, a plain squash and the error pulse.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int DEF_THREADS = 4;
  localparam int DEF_PC_W    = 32;
  localparam int DEF_DEPTH_W = 4;

  function automatic logic is_fixup(input logic v, input logic d,
                                    input logic m, input logic p);
    return v & d & m & p;
  endfunction
endpackage

// File: rtl/bmr_depth_bank.sv
module bmr_depth_bank #(
  parameter int NT = 4,
  parameter int DW = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enter,
  input  logic [TW-1:0] enter_tid,
  input  logic          fire,
  input  logic [TW-1:0] fire_tid,
  output logic          legal,
  output logic          last_level
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic [DW-1:0] depth [NT];
  logic [DW-1:0] sel_depth;
  logic          sel_inc;

  always_comb begin
    sel_depth = depth[fire_tid];
    sel_inc   = enter && (enter_tid == fire_tid) && (sel_depth != DMAX);
    legal      = sel_inc || (sel_depth != '0);
    last_level = sel_inc ? (sel_depth == '0) : (sel_depth == DW'(1));
  end

  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_thr
      logic inc, dec;
      always_comb begin
        inc = enter && (enter_tid == TW'(t)) && (depth[t] != DMAX);
        dec = fire && legal && (fire_tid == TW'(t));
      end
      always_ff @(posedge clk) begin
        if (rst)              depth[t] <= '0;
        else if (inc && !dec) depth[t] <= depth[t] + DW'(1);
        else if (dec && !inc) depth[t] <= depth[t] - DW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/bmr_out_reg.sv
module bmr_out_reg #(
  parameter int NT   = 4,
  parameter int PC_W = 32,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            legal,
  input  logic            last_level,
  input  logic [TW-1:0]   tid,
  input  logic [PC_W-1:0] target,
  output logic            squash_o,
  output logic [TW-1:0]   squash_tid_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            spec_reset_o,
  output logic [NT-1:0]   fetch_stall_o,
  output logic            depth_err_o
);
  logic take;
  assign take = fire && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      squash_o      <= 1'b0;
      squash_tid_o  <= '0;
      redirect_pc_o <= '0;
      spec_reset_o  <= 1'b0;
      fetch_stall_o <= '0;
      depth_err_o   <= 1'b0;
    end else begin
      squash_o      <= take;
      spec_reset_o  <= take && last_level;
      depth_err_o   <= fire && !legal;
      fetch_stall_o <= take ? (NT'(1) << tid) : '0;
      if (take) begin
        squash_tid_o  <= tid;
        redirect_pc_o <= target;
      end
    end
  end
endmodule

// File: rtl/branch_miss_redirect.sv
module branch_miss_redirect #(
  parameter int NUM_THREADS = bmr_pkg::DEF_THREADS,
  parameter int PC_W        = bmr_pkg::DEF_PC_W,
  parameter int DEPTH_W     = bmr_pkg::DEF_DEPTH_W,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dec_valid,
  input  logic [TID_W-1:0]       dec_tid,
  input  logic                   dec_direct,
  input  logic                   dec_miss,
  input  logic                   dec_pending,
  input  logic [PC_W-1:0]        dec_target,
  input  logic                   spec_enter,
  input  logic [TID_W-1:0]       spec_enter_tid,
  output logic                   squash_o,
  output logic [TID_W-1:0]       squash_tid_o,
  output logic [PC_W-1:0]        redirect_pc_o,
  output logic                   spec_reset_o,
  output logic [NUM_THREADS-1:0] fetch_stall_o,
  output logic                   depth_err_o
);
  logic fire, legal, last_level;

  assign fire = bmr_pkg::is_fixup(dec_valid, dec_direct, dec_miss, dec_pending);

  bmr_depth_bank #(.NT(NUM_THREADS), .DW(DEPTH_W)) u_depth (
    .clk(clk), .rst(rst),
    .enter(spec_enter), .enter_tid(spec_enter_tid),
    .fire(fire), .fire_tid(dec_tid),
    .legal(legal), .last_level(last_level)
  );

  bmr_out_reg #(.NT(NUM_THREADS), .PC_W(PC_W)) u_out (
    .clk(clk), .rst(rst),
    .fire(fire), .legal(legal), .last_level(last_level),
    .tid(dec_tid), .target(dec_target),
    .squash_o(squash_o), .squash_tid_o(squash_tid_o),
    .redirect_pc_o(redirect_pc_o), .spec_reset_o(spec_reset_o),
    .fetch_stall_o(fetch_stall_o), .depth_err_o(depth_err_o)
  );
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int NT   = 4,
  parameter int PC_W = 32,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            dec_valid,
  input logic [TW-1:0]   dec_tid,
  input logic            dec_direct,
  input logic            dec_miss,
  input logic            dec_pending,
  input logic [PC_W-1:0] dec_target,
  input logic            squash_o,
  input logic [TW-1:0]   squash_tid_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic            spec_reset_o,
  input logic [NT-1:0]   fetch_stall_o,
  input logic            depth_err_o
);
  // R1 / R2: a squash needs a fully qualifying instruction one cycle earlier
  a_r1_squash_qualified: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> $past(dec_valid && dec_direct && dec_miss && dec_pending));
  a_r2_no_err_unqualified: assert property (@(posedge clk) disable iff (rst)
    depth_err_o |-> $past(dec_valid && dec_direct && dec_miss && dec_pending));
  // R3: redirect carries the sampled target and thread
  a_r3_target: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> (redirect_pc_o == $past(dec_target)) && (squash_tid_o == $past(dec_tid)));
  // R5: reset only accompanies a squash
  a_r5_reset_with_squash: assert property (@(posedge clk) disable iff (rst)
    spec_reset_o |-> squash_o);
  // R6: stall vector tracks the squash
  a_r6_stall_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_stall_o));
  a_r6_stall_matches: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> fetch_stall_o[squash_tid_o]);
  a_r6_stall_only_squash: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall_o != '0) |-> squash_o);
  // R7: refusal and acceptance are exclusive
  a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
    depth_err_o |-> !squash_o);
endmodule

bind branch_miss_redirect bmr_checker #(.NT(NUM_THREADS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_tid(dec_tid),
  .dec_direct(dec_direct), .dec_miss(dec_miss), .dec_pending(dec_pending),
  .dec_target(dec_target), .squash_o(squash_o), .squash_tid_o(squash_tid_o),
  .redirect_pc_o(redirect_pc_o), .spec_reset_o(spec_reset_o),
  .fetch_stall_o(fetch_stall_o), .depth_err_o(depth_err_o)
);

// File: tb/tb_branch_miss_redirect.sv
module tb_branch_miss_redirect;
  localparam int NT = 4, PW = 32, DW = 4, TW = 2;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_valid = 0, dec_direct = 0, dec_miss = 0, dec_pending = 0, spec_enter = 0;
  logic [TW-1:0] dec_tid = 0, spec_enter_tid = 0;
  logic [PW-1:0] dec_target = 0;
  logic squash_o, spec_reset_o, depth_err_o;
  logic [TW-1:0] squash_tid_o;
  logic [PW-1:0] redirect_pc_o;
  logic [NT-1:0] fetch_stall_o;

  branch_miss_redirect #(.NUM_THREADS(NT), .PC_W(PW), .DEPTH_W(DW)) dut (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int depth [NT];
  bit e_sq, e_rs, e_err;
  int e_tid;
  logic [PW-1:0] e_pc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs against model (called away from the edge)
  task automatic compare(input string ctx);
    chk({ctx, " R1 squash"}, 64'(squash_o), 64'(e_sq));
    chk({ctx, " R7 err"}, 64'(depth_err_o), 64'(e_err));
    chk({ctx, " R5 spec_reset"}, 64'(spec_reset_o), 64'(e_rs));
    chk({ctx, " R6 stall"}, 64'(fetch_stall_o), e_sq ? 64'(1) << e_tid : 64'(0));
    if (e_sq) begin
      chk({ctx, " R3 pc"}, 64'(redirect_pc_o), 64'(e_pc));
      chk({ctx, " R3 tid"}, 64'(squash_tid_o), 64'(e_tid));
    end
  endtask

  // drive one cycle of inputs, update model, then check after the edge
  task automatic step(input string ctx, input bit v, input int tid, input bit d,
                      input bit m, input bit p, input logic [PW-1:0] tgt,
                      input bit en, input int etid);
    int eff;
    dec_valid = v; dec_tid = TW'(tid); dec_direct = d; dec_miss = m;
    dec_pending = p; dec_target = tgt; spec_enter = en; spec_enter_tid = TW'(etid);
    // model: entry first (R8), saturating (R4)
    if (en && depth[etid] < DMAX) depth[etid]++;
    e_sq = 0; e_rs = 0; e_err = 0;
    if (v && d && m && p) begin
      eff = depth[tid];
      if (eff == 0) e_err = 1;
      else begin
        e_sq = 1; e_tid = tid; e_pc = tgt;
        depth[tid] = eff - 1;
        e_rs = (depth[tid] == 0);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic idle();
    step("idle", 0, 0, 0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    foreach (depth[i]) depth[i] = 0;
    e_sq = 0; e_rs = 0; e_err = 0; e_tid = 0; e_pc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9 reset state
    chk("R9 squash", 64'(squash_o), 0);
    chk("R9 stall", 64'(fetch_stall_o), 0);
    chk("R9 err", 64'(depth_err_o), 0);
    chk("R9 reset", 64'(spec_reset_o), 0);
    // R9: depth zero after reset -> fix-up refused
    step("R9 depth0", 1, 1, 1, 1, 1, 32'h1000, 0, 0);
    // R4: two entries on thread 0
    step("R4 enter", 0, 0, 0, 0, 0, '0, 1, 0);
    step("R4 enter", 0, 0, 0, 0, 0, '0, 1, 0);
    // R2: each qualifier missing in turn, nothing happens
    step("R2 indirect", 1, 0, 0, 1, 1, 32'hdead0000, 0, 0);
    step("R2 hit", 1, 0, 1, 0, 1, 32'hdead0004, 0, 0);
    step("R2 notpend", 1, 0, 1, 1, 0, 32'hdead0008, 0, 0);
    step("R2 invalid", 0, 0, 1, 1, 1, 32'hdead000c, 0, 0);
    // R1 / R3: accepted, depth 2 -> 1, no reset
    step("R1 fix", 1, 0, 1, 1, 1, 32'h0000_4440, 0, 0);
    step("R6 after", 0, 0, 0, 0, 0, '0, 0, 0);
    // R5: depth 1 -> 0, reset
    step("R5 fix", 1, 0, 1, 1, 1, 32'h0000_8880, 0, 0);
    // R7: now zero
    step("R7 under", 1, 0, 1, 1, 1, 32'h0000_9990, 0, 0);
    // R8: same-cycle enter + fix on thread 2 from zero
    step("R8 same", 1, 2, 1, 1, 1, 32'hcafe_0010, 1, 2);
    // R8: enter on other thread does not help
    step("R8 other", 1, 3, 1, 1, 1, 32'hcafe_0020, 1, 2);
    // R4: saturate thread 1
    for (int i = 0; i < 20; i++) step("R4 sat", 0, 0, 0, 0, 0, '0, 1, 1);
    for (int i = 0; i < DMAX + 1; i++)
      step("R4 drain", 1, 1, 1, 1, 1, 32'h100 + 32'(i), 0, 0);
    // back-to-back fixes on different threads (R6)
    step("R6 a", 0, 0, 0, 0, 0, '0, 1, 3);
    step("R6 b", 1, 3, 1, 1, 1, 32'h7777_0000, 1, 0);
    step("R6 c", 1, 0, 1, 1, 1, 32'h7777_1000, 0, 0);
    idle();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      step("rand", r < 60, int'($urandom_range(0, NT-1)), r < 50 || r > 80,
           r != 7, r != 9, $urandom, $urandom_range(0, 2) != 0,
           int'($urandom_range(0, NT-1)));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule